// File: doc/BRIEF.md
# Fault Reaction and Retry Controller

This block decides how a three-phase bridge driver reacts to one fault source. A raw fault-detect level first passes a deglitch filter whose window is picked from a coded table. Once the fault is qualified, a 4-bit reaction mode chooses the response. The block can hold the fault until software clears it. It can release it by itself after a coded wait. It can only flag it on the fault pin. Or it can ignore it.

For the holding and self-releasing responses, the mode also chooses the bridge override: all switches off, recirculation, all high-side switches on, or all low-side switches on. Self-releasing responses are counted. When the count of automatic releases reaches a coded limit, the next fault is held instead. A quiet period of one full retry interval resets the count, and so does a clear pulse.

All timers advance on an enable tick `tick_i`. The tick period is a parameter (`TICK_US`, default 50 µs). Every coded time is divided by it, with a minimum of one tick.

Top module: `fault_retry_ctrl`

## Requirements
- R1: After reset `fault_no`=1, `act_o`=0, `latched_o`=0 and `bridge_o`=0.
- R2: A fault is qualified only after `fault_raw_i` has been high for the full deglitch window of consecutive ticks. A single low cycle restarts the count. Two cycles after `fault_raw_i` has been low, no new fault reaction may start.
- R3: The deglitch window code `deg_sel_i` selects 0.05, 0.1, 0.2, 0.5, 1, 2.5, 5, 7.5, 10, 25, 50, 75, 100, 200, 500 or 1000 ms for codes 0 through 15.
- R4: Mode codes 0 to 3 hold the fault: `fault_no`=0, `act_o`=1, `latched_o`=1, and `bridge_o` equals the mode's two low bits (0 off, 1 recirculate, 2 high-side on, 3 low-side on). This lasts until a clear pulse.
- R5: Mode codes 4 to 7 drive the same bridge states with `latched_o`=0. The fault is released by itself once the retry wait has elapsed.
- R6: The retry wait code `retry_sel_i` selects 100 ms for code 0 and 500 ms for code 1. Codes 2 to 15 select (code−1) seconds.
- R7: The retry limit code `limit_sel_i` selects unlimited (0), 2, 3, 5, 7, 10, 15 or 20. When the number of automatic releases has reached the limit, the next fault is held with the bridge state of its mode.
- R8: Mode 8 drives `fault_no`=0 while the qualified fault lasts, with `act_o`=0 and `bridge_o`=0.
- R9: Mode codes 9 to 15 ignore the fault: outputs stay at their idle values.
- R10: A one-cycle `clr_flt_i` pulse returns the block to idle on the next cycle and zeroes the release count.
- R11: After an automatic release, one full retry interval with no qualified fault zeroes the release count.
- R12: The mode is captured when a fault is taken. Mode changes during an active fault do not change the bridge state or the policy until the next fault.
- R13: Deglitch and retry timers advance only in cycles where `tick_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer enable, one pulse per `TICK_US` |
| fault_raw_i | input | 1 | Raw fault-detect level |
| mode_i | input | 4 | Reaction mode code |
| deg_sel_i | input | 4 | Deglitch window code |
| retry_sel_i | input | 4 | Retry wait code |
| limit_sel_i | input | 3 | Retry limit code |
| clr_flt_i | input | 1 | Fault clear pulse |
| fault_no | output | 1 | Fault pin, active low |
| bridge_o | output | 2 | Bridge override state |
| act_o | output | 1 | Bridge override active |
| latched_o | output | 1 | Fault held until cleared |

## Verification
Every cycle, the assertions check the relations between the outputs:
- a held fault always drives the override and the fault pin;
- the bridge state never changes while the override stays on;
- a clear pulse always returns the block to idle;
- disabled modes and a low input never start a reaction;
- a pending retry never advances without a tick.

Only the bench's scenarios can show the coded time and limit tables, the exact cycle of qualification and release, and the release-count behaviour across a quiet interval. It shows them by comparing against a cycle model through long retry sequences, with the limit reached, unlimited, and reset by quiet time.

// File: rtl/fr_pkg.sv
package fr_pkg;
  typedef enum logic [1:0] {
    BR_OFF    = 2'd0,
    BR_RECIRC = 2'd1,
    BR_HS_ON  = 2'd2,
    BR_LS_ON  = 2'd3
  } bridge_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RETRY  = 2'd1,
    ST_LATCH  = 2'd2,
    ST_REPORT = 2'd3
  } react_st_e;

  localparam int unsigned DEG_MAX_US = 1000000;
  localparam int unsigned RTY_MAX_US = 14000000;

  function automatic int unsigned deg_us(input logic [3:0] c);
    case (c)
      4'd0:  return 50;
      4'd1:  return 100;
      4'd2:  return 200;
      4'd3:  return 500;
      4'd4:  return 1000;
      4'd5:  return 2500;
      4'd6:  return 5000;
      4'd7:  return 7500;
      4'd8:  return 10000;
      4'd9:  return 25000;
      4'd10: return 50000;
      4'd11: return 75000;
      4'd12: return 100000;
      4'd13: return 200000;
      4'd14: return 500000;
      default: return 1000000;
    endcase
  endfunction

  function automatic int unsigned retry_us(input logic [3:0] c);
    if (c == 4'd0) return 100000;
    if (c == 4'd1) return 500000;
    return (int'(c) - 1) * 1000000;
  endfunction

  function automatic int unsigned limit_val(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 3;
      3'd3: return 5;
      3'd4: return 7;
      3'd5: return 10;
      3'd6: return 15;
      default: return 20;
    endcase
  endfunction

  function automatic int unsigned to_ticks(input int unsigned us, input int unsigned tick_us);
    int unsigned t;
    t = us / tick_us;
    return (t == 0) ? 1 : t;
  endfunction
endpackage

// File: rtl/fr_code_decode.sv
module fr_code_decode #(
  parameter int unsigned TICK_US = 50,
  parameter int unsigned DEG_W   = 15,
  parameter int unsigned RTY_W   = 19,
  parameter int unsigned CNT_W   = 5
) (
  input  logic [3:0]       deg_sel_i,
  input  logic [3:0]       retry_sel_i,
  input  logic [2:0]       limit_sel_i,
  output logic [DEG_W-1:0] deg_ticks_o,
  output logic [RTY_W-1:0] retry_ticks_o,
  output logic [CNT_W-1:0] limit_o
);
  import fr_pkg::*;

  always_comb begin
    deg_ticks_o   = DEG_W'(to_ticks(deg_us(deg_sel_i), TICK_US));
    retry_ticks_o = RTY_W'(to_ticks(retry_us(retry_sel_i), TICK_US));
    limit_o       = CNT_W'(limit_val(limit_sel_i));
  end
endmodule

// File: rtl/fr_deglitch.sv
module fr_deglitch #(
  parameter int unsigned W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         raw_i,
  input  logic [W-1:0] thr_i,
  output logic         qual_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      qual_o <= 1'b0;
    end else if (!raw_i) begin
      cnt_q  <= '0;
      qual_o <= 1'b0;
    end else if (!qual_o && tick_i) begin
      if (cnt_q + 1'b1 >= thr_i) begin
        qual_o <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fr_reaction_fsm.sv
module fr_reaction_fsm #(
  parameter int unsigned TW    = 19,
  parameter int unsigned CNT_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              qual_i,
  input  logic              clr_i,
  input  logic [3:0]        mode_i,
  input  logic [TW-1:0]     retry_ticks_i,
  input  logic [CNT_W-1:0]  limit_i,
  output fr_pkg::react_st_e state_o,
  output logic [3:0]        mode_q_o
);
  import fr_pkg::*;

  logic [TW-1:0]    tmr_q;
  logic [CNT_W-1:0] rcnt_q;
  logic             tmr_done;
  logic             lim_hit;

  assign tmr_done = (tmr_q + 1'b1) >= retry_ticks_i;
  assign lim_hit  = (limit_i != '0) && (rcnt_q >= limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o  <= ST_IDLE;
      mode_q_o <= '0;
      tmr_q    <= '0;
      rcnt_q   <= '0;
    end else if (clr_i) begin
      state_o <= ST_IDLE;
      tmr_q   <= '0;
      rcnt_q  <= '0;
    end else begin
      unique case (state_o)
        ST_IDLE: begin
          if (qual_i && !mode_i[3]) begin
            mode_q_o <= mode_i;
            tmr_q    <= '0;
            if (!mode_i[2] || lim_hit) state_o <= ST_LATCH;
            else                       state_o <= ST_RETRY;
          end else if (qual_i && mode_i == 4'd8) begin
            mode_q_o <= mode_i;
            state_o  <= ST_REPORT;
          end else if (qual_i || rcnt_q == '0) begin
            tmr_q <= '0;
          end else if (tick_i) begin
            // quiet interval after a retry clears the count
            if (tmr_done) begin
              rcnt_q <= '0;
              tmr_q  <= '0;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        ST_RETRY: begin
          if (tick_i) begin
            if (tmr_done) begin
              state_o <= ST_IDLE;
              tmr_q   <= '0;
              if (rcnt_q != '1) rcnt_q <= rcnt_q + 1'b1;
            end else begin
              tmr_q <= tmr_q + 1'b1;
            end
          end
        end
        ST_LATCH: state_o <= ST_LATCH;
        ST_REPORT: if (!qual_i) state_o <= ST_IDLE;
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fault_retry_ctrl.sv
module fault_retry_ctrl #(
  parameter int unsigned TICK_US = 50,
  parameter int unsigned CNT_W   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       fault_raw_i,
  input  logic [3:0] mode_i,
  input  logic [3:0] deg_sel_i,
  input  logic [3:0] retry_sel_i,
  input  logic [2:0] limit_sel_i,
  input  logic       clr_flt_i,
  output logic       fault_no,
  output logic [1:0] bridge_o,
  output logic       act_o,
  output logic       latched_o
);
  import fr_pkg::*;

  localparam int unsigned DEG_W = $clog2(DEG_MAX_US / TICK_US + 1);
  localparam int unsigned RTY_W = $clog2(RTY_MAX_US / TICK_US + 1);

  logic [DEG_W-1:0] deg_ticks;
  logic [RTY_W-1:0] retry_ticks;
  logic [CNT_W-1:0] limit;
  logic             qual;
  react_st_e        state;
  logic [3:0]       mode_q;

  fr_code_decode #(
    .TICK_US(TICK_US), .DEG_W(DEG_W), .RTY_W(RTY_W), .CNT_W(CNT_W)
  ) u_dec (
    .deg_sel_i    (deg_sel_i),
    .retry_sel_i  (retry_sel_i),
    .limit_sel_i  (limit_sel_i),
    .deg_ticks_o  (deg_ticks),
    .retry_ticks_o(retry_ticks),
    .limit_o      (limit)
  );

  fr_deglitch #(.W(DEG_W)) u_deg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .raw_i (fault_raw_i),
    .thr_i (deg_ticks),
    .qual_o(qual)
  );

  fr_reaction_fsm #(.TW(RTY_W), .CNT_W(CNT_W)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick_i),
    .qual_i       (qual),
    .clr_i        (clr_flt_i),
    .mode_i       (mode_i),
    .retry_ticks_i(retry_ticks),
    .limit_i      (limit),
    .state_o      (state),
    .mode_q_o     (mode_q)
  );

  always_comb begin
    fault_no  = (state == ST_IDLE);
    act_o     = (state == ST_RETRY) || (state == ST_LATCH);
    latched_o = (state == ST_LATCH);
    bridge_o  = act_o ? mode_q[1:0] : BR_OFF;
  end
endmodule

// File: rtl/fault_retry_ctrl_chk.sv
module fault_retry_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       fault_raw_i,
  input logic [3:0] mode_i,
  input logic       clr_flt_i,
  input logic       fault_no,
  input logic [1:0] bridge_o,
  input logic       act_o,
  input logic       latched_o
);
  p_latch_drives_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latched_o |-> (act_o && !fault_no));

  p_latch_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (latched_o && !clr_flt_i) |=> latched_o);

  p_act_pin_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> !fault_no);

  p_bridge_stable_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && $past(act_o)) |-> $stable(bridge_o));

  p_clear_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_flt_i |=> (fault_no && !act_o));

  p_disabled_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_no && mode_i > 4'd8) |=> fault_no);

  p_low_input_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_no && !$past(fault_raw_i)) |=> fault_no);

  p_no_tick_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_o && !latched_o && !tick_i && !clr_flt_i) |=> (act_o && !latched_o));
endmodule

bind fault_retry_ctrl fault_retry_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick_i),
  .fault_raw_i(fault_raw_i),
  .mode_i     (mode_i),
  .clr_flt_i  (clr_flt_i),
  .fault_no   (fault_no),
  .bridge_o   (bridge_o),
  .act_o      (act_o),
  .latched_o  (latched_o)
);

// File: tb/fault_retry_ctrl_test.sv
module fault_retry_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic raw = 1'b0;
  logic [3:0] mode = 4'd0;
  logic [3:0] deg_sel = 4'd0;
  logic [3:0] rty_sel = 4'd0;
  logic [2:0] lim_sel = 3'd0;
  logic clr = 1'b0;
  logic fault_n;
  logic [1:0] bridge;
  logic act;
  logic latched;

  int n_cmp = 0;
  int n_bad = 0;
  string tag = "R1";
  bit done = 0;

  always #5 clk = ~clk;

  fault_retry_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .fault_raw_i(raw),
    .mode_i(mode), .deg_sel_i(deg_sel), .retry_sel_i(rty_sel),
    .limit_sel_i(lim_sel), .clr_flt_i(clr), .fault_no(fault_n),
    .bridge_o(bridge), .act_o(act), .latched_o(latched)
  );

  // reference tables in milliseconds*20 (units of 50 us ticks)
  function automatic int deg_t(int c);
    int ms100[16] = '{5, 10, 20, 50, 100, 250, 500, 750, 1000, 2500, 5000,
                      7500, 10000, 20000, 50000, 100000};
    return ms100[c] * 10 / 50;
  endfunction
  function automatic int rty_t(int c);
    if (c == 0) return 2000;
    if (c == 1) return 10000;
    return (c - 1) * 20000;
  endfunction
  function automatic int lim_v(int c);
    int t[8] = '{0, 2, 3, 5, 7, 10, 15, 20};
    return t[c];
  endfunction

  // behavioural reference: 0 idle, 1 waiting retry, 2 held, 3 reporting
  int m_cnt, m_state, m_mode, m_rel, m_quiet;
  bit m_qual;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_qual = 0; m_state = 0; m_mode = 0; m_rel = 0; m_quiet = 0;
    end else begin
      bit q;
      q = m_qual;
      if (clr) begin
        m_state = 0; m_rel = 0; m_quiet = 0;
      end else if (m_state == 0) begin
        if (q && mode < 8) begin
          m_mode = mode; m_quiet = 0;
          if (mode < 4 || (lim_v(lim_sel) != 0 && m_rel >= lim_v(lim_sel))) m_state = 2;
          else m_state = 1;
        end else if (q && mode == 8) begin
          m_mode = 8; m_state = 3;
        end else if (q || m_rel == 0) m_quiet = 0;
        else if (tick) begin
          m_quiet++;
          if (m_quiet >= rty_t(rty_sel)) begin m_rel = 0; m_quiet = 0; end
        end
      end else if (m_state == 1) begin
        if (tick) begin
          m_quiet++;
          if (m_quiet >= rty_t(rty_sel)) begin
            m_state = 0; m_quiet = 0; if (m_rel < 31) m_rel++;
          end
        end
      end else if (m_state == 3) begin
        if (!q) m_state = 0;
      end
      if (!raw) begin m_cnt = 0; m_qual = 0; end
      else if (!m_qual && tick) begin
        m_cnt++;
        if (m_cnt >= deg_t(deg_sel)) begin m_qual = 1; m_cnt = 0; end
      end
    end
  end

  task automatic chk(string req, string nm, int a, int e);
    n_cmp++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, nm, a, e, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    int ea;
    ea = (m_state == 1 || m_state == 2) ? 1 : 0;
    chk(tag, "fault_no", fault_n, m_state == 0);
    chk(tag, "act_o", act, ea);
    chk(tag, "latched_o", latched, m_state == 2);
    chk(tag, "bridge_o", bridge, ea ? (m_mode % 4) : 0);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_clr();
    clr = 1; cyc(1); clr = 0; cyc(1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(2);
    // R1: reset values seen at the pins while reset is held
    chk("R1", "fault_no", fault_n, 1);
    chk("R1", "act_o", act, 0);
    chk("R1", "latched_o", latched, 0);
    chk("R1", "bridge_o", bridge, 0);
    rst_n = 1; cyc(3);

    tag = "R9"; mode = 4'd9; raw = 1; cyc(20);
    mode = 4'd15; cyc(10);
    chk("R9", "fault_no", fault_n, 1);
    raw = 0; cyc(3);

    tag = "R2"; deg_sel = 4'd2; mode = 4'd1;
    raw = 1; cyc(3); raw = 0; cyc(1); raw = 1; cyc(3); raw = 0; cyc(2);
    chk("R2", "fault_no", fault_n, 1);
    tag = "R4"; raw = 1; cyc(8);
    chk("R4", "bridge_o", bridge, 1);
    chk("R4", "latched_o", latched, 1);
    raw = 0; cyc(5);
    tag = "R10"; pulse_clr();
    chk("R10", "fault_no", fault_n, 1);

    tag = "R3"; deg_sel = 4'd3; mode = 4'd3; raw = 1; cyc(9);
    chk("R3", "fault_no", fault_n, 1);
    cyc(4);
    chk("R4", "bridge_o", bridge, 3);
    raw = 0; mode = 4'd0; cyc(3); pulse_clr();
    deg_sel = 4'd0; mode = 4'd0; raw = 1; cyc(4); raw = 0; cyc(2);
    chk("R4", "bridge_o", bridge, 0);
    pulse_clr();

    tag = "R5"; mode = 4'd6; lim_sel = 3'd1; rty_sel = 4'd0;
    raw = 1; cyc(3); raw = 0; cyc(10);
    chk("R5", "bridge_o", bridge, 2);
    chk("R5", "latched_o", latched, 0);
    cyc(2100);
    chk("R5", "fault_no", fault_n, 1);
    tag = "R7"; raw = 1; cyc(3); raw = 0; cyc(2100);
    raw = 1; cyc(3); raw = 0; cyc(10);
    chk("R7", "latched_o", latched, 1);
    chk("R7", "bridge_o", bridge, 2);
    pulse_clr();

    tag = "R11"; mode = 4'd5;
    raw = 1; cyc(3); raw = 0; cyc(2100);
    cyc(2100);
    raw = 1; cyc(3); raw = 0; cyc(2100);
    raw = 1; cyc(3); raw = 0; cyc(10);
    chk("R11", "latched_o", latched, 0);
    cyc(2100); pulse_clr();

    tag = "R7"; lim_sel = 3'd0; mode = 4'd4; raw = 1; cyc(7000);
    chk("R7", "latched_o", latched, 0);
    raw = 0; cyc(2100); pulse_clr();

    tag = "R12"; mode = 4'd6; raw = 1; cyc(3); raw = 0; cyc(5);
    mode = 4'd7; cyc(50);
    chk("R12", "bridge_o", bridge, 2);
    cyc(2100);
    raw = 1; cyc(3); raw = 0; cyc(5);
    chk("R12", "bridge_o", bridge, 3);
    cyc(2100); pulse_clr();

    tag = "R8"; mode = 4'd8; raw = 1; cyc(5);
    chk("R8", "fault_no", fault_n, 0);
    chk("R8", "act_o", act, 0);
    raw = 0; cyc(3);
    chk("R8", "fault_no", fault_n, 1);

    tag = "R13"; mode = 4'd1; deg_sel = 4'd3;
    raw = 1;
    for (int i = 0; i < 60; i++) begin tick = (i % 4 == 0); cyc(1); end
    tick = 1;
    chk("R13", "latched_o", latched, 1);
    raw = 0; cyc(2); pulse_clr();

    tag = "R6"; deg_sel = 4'd0; rty_sel = 4'd1; mode = 4'd4; lim_sel = 3'd2;
    raw = 1; cyc(3); raw = 0; cyc(9000);
    chk("R6", "act_o", act, 1);
    cyc(1100);
    chk("R6", "act_o", act, 0);
    cyc(5);
    finish_run();
  end
endmodule